// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose target device has been left mid-byte and keeps pulling SDA low. A single-cycle `kick` starts a fixed recovery waveform on the open-drain SCL and SDA drivers. The waveform has four parts: a start condition, nine clock pulses with SDA released, a repeated start, and a stop. The block then samples SDA once. It ends with a one-cycle `done` pulse. `bus_clear` reports whether SDA was found high, and it holds that value until the next accepted trigger.

Each start condition first looks at SDA. If SDA is already low, the block gives one extra SCL low/high pulse to coax the target into letting go, and only then pulls SDA low under a high SCL. Every line interval is a whole number of clock cycles, taken from two parameters: the low-phase length and the high-phase length. SDA never changes in the same cycle as SCL, except for the start and stop edges, which are made with SCL held high.

The transfer engine that shares the bus drives `xfer_busy`. A trigger that arrives while it is high is dropped. `running` tells that engine the sequencer owns the bus.

Top module: `i2c_unjam`

## Requirements
- R1: After reset, and whenever the sequencer is idle, both `scl_out` and `sda_out` are 1 (released), `running` is 0 and `done` is 0. `bus_clear` is 0 after reset.
- R2: `kick` is accepted only in an idle cycle with `xfer_busy` low. A `kick` in a cycle with `xfer_busy` high is ignored. A `kick` while `running` is 1 is ignored, and the waveform in progress is unchanged.
- R3: Each start condition checks `sda_in`. If it is 0, the start begins with SCL low for LOW_CYC cycles and then SCL high for LOW_CYC cycles, with SDA released. The start then drives SDA low with SCL high for HIGH_CYC cycles, and then drives SCL low with SDA low for LOW_CYC cycles. SDA falls only while SCL is high, and SDA never changes in the same cycle as SCL.
- R4: After the first start, SDA is released for one cycle with SCL low. Then exactly nine clock slots follow, each with SCL high for HIGH_CYC cycles and then SCL low for LOW_CYC cycles, with SDA released throughout.
- R5: After the ninth slot, both lines are released for HIGH_CYC+LOW_CYC cycles. A second start condition per R3 follows, including its own SDA check.
- R6: The stop holds SDA low with SCL low for LOW_CYC cycles (which directly follows the second start's low phase). It then holds SCL high with SDA low for 2*HIGH_CYC cycles, and then releases SDA for LOW_CYC cycles before a single check cycle.
- R7: `done` is 1 for exactly one cycle, in the cycle after the check cycle. `bus_clear` then equals `sda_in` as sampled in the check cycle (1 = clear, 0 = still held low). It stays unchanged until the next accepted `kick`, which clears it to 0.
- R8: `running` is 1 from the cycle after an accepted `kick` up to and including the check cycle, and is 0 in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start a recovery sequence |
| xfer_busy | input | 1 | Transfer engine owns the bus; triggers are dropped |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_out | output | 1 | SDA drive: 0 pulls low, 1 releases |
| running | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| bus_clear | output | 1 | Result of the final SDA check, held until next trigger |

## Verification
A wrong state or a bad reload of the interval timer changes the line pattern at the ports within one interval. The bench sees it as a segment with the wrong level pair or the wrong length, at the first transition after the fault. An off-by-one in the pulse counter adds or drops a whole high/low slot, so the repeated start appears one slot period early or late. A wrong SDA decision at either start adds or drops the extra SCL pulse. A wrong final sample shows on `bus_clear` in the single `done` cycle.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNST_LO,
        ST_UNST_HI,
        ST_ST_HOLD,
        ST_ST_LOW,
        ST_REL,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_RS_HI,
        ST_RS_SETUP,
        ST_SP_LOW,
        ST_SP_HI1,
        ST_SP_HI2,
        ST_SP_REL,
        ST_CHECK
    } unjam_st_e;

    typedef struct packed {
        unjam_st_e st;
        logic      second;
        logic      scl;
        logic      sda;
        logic      run;
        logic      done;
        logic      clear;
    } unjam_regs_t;

endpackage

// File: rtl/unjam_timer.sv
module unjam_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/unjam_pulse_ctr.sv
module unjam_pulse_ctr #(
    parameter int LIMIT = 9,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
        else          cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/i2c_unjam.sv
module i2c_unjam
    import unjam_pkg::*;
#(
    parameter int LOW_CYC  = 588,
    parameter int HIGH_CYC = 500,
    parameter int PULSES   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic xfer_busy,
    input  logic sda_in,
    output logic scl_out,
    output logic sda_out,
    output logic running,
    output logic done,
    output logic bus_clear
);
    localparam int MAXD = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int TW   = $clog2(MAXD + 1);
    localparam int PCW  = $clog2(PULSES + 1);

    unjam_regs_t r_d, r_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          ctr_clr;
    logic          ctr_inc;
    logic [PCW-1:0] pulse_cnt;
    logic          pulse_last;

    // Interval length (minus one) spent in each state.
    function automatic logic [TW-1:0] hold_len(input unjam_st_e s);
        case (s)
            ST_ST_HOLD, ST_CLK_HI, ST_RS_HI,
            ST_SP_HI1, ST_SP_HI2:            hold_len = TW'(HIGH_CYC - 1);
            ST_UNST_LO, ST_UNST_HI, ST_ST_LOW,
            ST_CLK_LO, ST_RS_SETUP,
            ST_SP_LOW, ST_SP_REL:            hold_len = TW'(LOW_CYC - 1);
            default:                         hold_len = '0;
        endcase
    endfunction

    function automatic logic scl_level(input unjam_st_e s);
        case (s)
            ST_UNST_LO, ST_ST_LOW, ST_REL,
            ST_CLK_LO, ST_SP_LOW:            scl_level = 1'b0;
            default:                         scl_level = 1'b1;
        endcase
    endfunction

    function automatic logic sda_level(input unjam_st_e s);
        case (s)
            ST_ST_HOLD, ST_ST_LOW, ST_SP_LOW,
            ST_SP_HI1, ST_SP_HI2:            sda_level = 1'b0;
            default:                         sda_level = 1'b1;
        endcase
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (kick && !xfer_busy) begin
                r_d.st     = sda_in ? ST_ST_HOLD : ST_UNST_LO;
                r_d.second = 1'b0;
                r_d.clear  = 1'b0;
                ctr_clr    = 1'b1;
            end
        end else if (tmr_exp) begin
            case (r_q.st)
                ST_UNST_LO:  r_d.st = ST_UNST_HI;
                ST_UNST_HI:  r_d.st = ST_ST_HOLD;
                ST_ST_HOLD:  r_d.st = ST_ST_LOW;
                ST_ST_LOW:   r_d.st = r_q.second ? ST_SP_LOW : ST_REL;
                ST_REL:      r_d.st = ST_CLK_HI;
                ST_CLK_HI:   r_d.st = ST_CLK_LO;
                ST_CLK_LO: begin
                    ctr_inc = 1'b1;
                    r_d.st  = pulse_last ? ST_RS_HI : ST_CLK_HI;
                end
                ST_RS_HI:    r_d.st = ST_RS_SETUP;
                ST_RS_SETUP: begin
                    r_d.second = 1'b1;
                    r_d.st     = sda_in ? ST_ST_HOLD : ST_UNST_LO;
                end
                ST_SP_LOW:   r_d.st = ST_SP_HI1;
                ST_SP_HI1:   r_d.st = ST_SP_HI2;
                ST_SP_HI2:   r_d.st = ST_SP_REL;
                ST_SP_REL:   r_d.st = ST_CHECK;
                ST_CHECK: begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.clear = sda_in;
                end
                default:     r_d.st = ST_IDLE;
            endcase
        end
        r_d.scl = scl_level(r_d.st);
        r_d.sda = sda_level(r_d.st);
        r_d.run = (r_d.st != ST_IDLE);
    end

    assign tmr_load = (r_d.st != r_q.st);
    assign tmr_val  = hold_len(r_d.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, second: 1'b0, scl: 1'b1, sda: 1'b1,
                     run: 1'b0, done: 1'b0, clear: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    unjam_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .val     (tmr_val),
        .expired (tmr_exp)
    );

    unjam_pulse_ctr #(.LIMIT(PULSES), .W(PCW)) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .cnt   (pulse_cnt),
        .last  (pulse_last)
    );

    assign scl_out   = r_q.scl;
    assign sda_out   = r_q.sda;
    assign running   = r_q.run;
    assign done      = r_q.done;
    assign bus_clear = r_q.clear;
endmodule

// File: rtl/unjam_chk.sv
module unjam_chk
    import unjam_pkg::*;
#(
    parameter int PULSES = 9,
    parameter int PCW    = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           kick,
    input logic           xfer_busy,
    input logic           scl_out,
    input logic           sda_out,
    input logic           running,
    input logic           done,
    input logic           bus_clear,
    input unjam_st_e      st,
    input logic [PCW-1:0] pcnt
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (scl_out && sda_out));

    a_r2_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && kick && xfer_busy) |=> !running);

    a_r3_sda_fall_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_out) |-> scl_out);

    a_r3_no_joint_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_out) |-> $stable(scl_out));

    a_r4_count_max: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PCW'(PULSES));

    a_r5_rs_after_nine: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RS_HI && $past(st) != ST_RS_HI) |-> (pcnt == PCW'(PULSES)));

    a_r6_check_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK) |-> ($past(st) == ST_SP_REL));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> $stable(bus_clear));

    a_r8_run_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(running) && !running));
endmodule

bind i2c_unjam unjam_chk #(.PULSES(PULSES), .PCW(PCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .xfer_busy (xfer_busy),
    .scl_out   (scl_out),
    .sda_out   (sda_out),
    .running   (running),
    .done      (done),
    .bus_clear (bus_clear),
    .st        (r_q.st),
    .pcnt      (pulse_cnt)
);

// File: tb/sim_i2c_unjam.sv
`timescale 1ns/1ps
module sim_i2c_unjam;
    localparam int L = 5;
    localparam int H = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0;
    logic xfer_busy = 1'b0;
    logic sda_in;
    logic scl_out, sda_out, running, done, bus_clear;

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // Bus model: target holds SDA low until it has seen rel_after SCL falls.
    int  bus_mode  = 0;
    int  rel_after = 0;
    int  falls     = 0;
    int  fall_base = 0;
    logic stuck;
    always @(negedge scl_out) falls = falls + 1;
    assign stuck  = (bus_mode != 0) && ((falls - fall_base) < rel_after);
    assign sda_in = sda_out & ~stuck;

    i2c_unjam #(.LOW_CYC(L), .HIGH_CYC(H), .PULSES(9)) u0 (
        .clk(clk), .rst_n(rst_n), .kick(kick), .xfer_busy(xfer_busy),
        .sda_in(sda_in), .scl_out(scl_out), .sda_out(sda_out),
        .running(running), .done(done), .bus_clear(bus_clear)
    );

    typedef struct packed {
        logic        scl;
        logic        sda;
        logic [15:0] len;
        logic [3:0]  req;
    } seg_t;
    seg_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic c, input logic d, input int n, input int rq);
        seg_t s;
        s.scl = c; s.sda = d; s.len = 16'(n); s.req = 4'(rq);
        exp_q.push_back(s);
    endtask

    // Expected waveform; segment = (scl, sda, cycles). Tags R3..R6 per part.
    task automatic build(input bit p1, input bit p2);
        if (p1) begin push(0, 1, L, 3); push(1, 1, L, 3); end   // R3 unstick pulse
        push(1, 0, H, 3); push(0, 0, L, 3);                       // R3 start
        push(0, 1, 1, 4);                                         // R4 release
        for (int i = 0; i < 9; i++) begin
            push(1, 1, H, 4); push(0, 1, L, 4);                   // R4 slots
        end
        push(1, 1, H + L, 5);                                     // R5 rep. start idle
        if (p2) begin push(0, 1, L, 5); push(1, 1, L, 5); end
        push(1, 0, H, 5);
        push(0, 0, 2 * L, 6);                                     // R6 stop low
        push(1, 0, 2 * H, 6);                                     // R6 stop high
    endtask

    // Monitor: closes segments on every level change and compares them.
    logic p_scl = 1'b1, p_sda = 1'b1, seg_ok = 1'b0;
    int   seg_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if ({scl_out, sda_out} != {p_scl, p_sda}) begin
                if (seg_ok) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R4", "unexpected segment", seg_len, 0);
                    end else begin
                        seg_t e;
                        e = exp_q.pop_front();
                        check(e.scl == p_scl && e.sda == p_sda,
                              $sformatf("R%0d", e.req), "segment levels",
                              {p_scl, p_sda}, {e.scl, e.sda});
                        check(e.len == 16'(seg_len),
                              $sformatf("R%0d", e.req), "segment length",
                              seg_len, int'(e.len));
                    end
                end
                seg_len = 1;
                seg_ok  = running && !done;
            end else begin
                seg_len = seg_len + 1;
            end
            if (done) seg_ok = 1'b0;
            p_scl = scl_out;
            p_sda = sda_out;
        end
    end

    task automatic run_case(input int mode, input int rel, input bit p1,
                            input bit p2, input bit exp_clear, input bit mid_kick);
        int waited;
        bus_mode = mode; rel_after = rel; fall_base = falls;
        build(p1, p2);
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        check(running == 1'b1, "R8", "running after kick", running, 1);
        check(bus_clear == 1'b0, "R7", "status cleared on accept", bus_clear, 0);
        if (mid_kick) begin
            repeat (20) @(negedge clk);
            kick = 1'b1;                    // R2: ignored while running
            @(negedge clk); kick = 1'b0;
        end
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk); waited++;
        end
        check(done == 1'b1, "R7", "done seen", done, 1);
        check(bus_clear == exp_clear, "R7", "bus_clear", bus_clear, exp_clear);
        check(running == 1'b0, "R8", "running low at done", running, 0);
        check(exp_q.size() == 0, "R6", "segments left", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(done == 1'b0, "R7", "done one cycle", done, 0);
        repeat (6) @(negedge clk);
        check(bus_clear == exp_clear, "R7", "status held", bus_clear, exp_clear);
        check(scl_out && sda_out, "R1", "idle released", {scl_out, sda_out}, 3);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        check(scl_out == 1'b1 && sda_out == 1'b1, "R1", "reset lines",
              {scl_out, sda_out}, 3);
        check(running == 1'b0, "R1", "reset running", running, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);
        check(bus_clear == 1'b0, "R1", "reset bus_clear", bus_clear, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: trigger while the transfer engine is busy is dropped
        xfer_busy = 1'b1; kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check(running == 1'b0 && scl_out && sda_out && !done, "R2",
                  "busy trigger ignored", {running, scl_out, sda_out, done}, 6);
            @(negedge clk);
        end
        xfer_busy = 1'b0;

        run_case(0, 0,    0, 0, 1, 0);   // free bus
        run_case(1, 3,    1, 0, 1, 1);   // freed during the nine pulses; R2 mid-run kick
        run_case(1, 1000, 1, 1, 0, 0);   // never freed: bus busy
        run_case(1, 12,   1, 1, 1, 0);   // freed by the repeated start's extra pulse
        run_case(0, 0,    0, 0, 1, 0);   // status goes back to clear

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule